// File: doc/BRIEF.md
# Per-Port Packet Framing Checker

This block sits on a word stream in which every word carries an 8-bit port address together with start and end markers. Packets from different ports may be interleaved word by word. The block keeps one in-packet bit for each checked port, so each port's framing is judged on its own. Any word that breaks the framing of its port is repaired where the repair can be made in the word itself, and the word is flagged as an error with a code that gives the kind of fault.

The number of checked ports is a parameter and must be a power of two, at least 2. Only the low log2(NUM_PORTS) address bits select the port state. The full 8-bit address still travels to the output unchanged, so the upper bits stay free for packet classification. Every word leaves through a single output register, one cycle after it is accepted. A low downstream ready holds that register and stops input acceptance.

Top module: `fc_frame_checker`

## Requirements
- R1: An accepted word appears on the output exactly one cycle later. Its 8-bit address, data and end marker are unchanged, all address bits included.
- R2: The port state is selected by address bits [log2(NUM_PORTS)-1:0] only. With NUM_PORTS=4, a word for address 6 continues a packet that was opened on address 2.
- R3: A word without a start marker, for a port that is idle, leaves with the start marker forced to 1, the error flag set and error code 1 (missing start).
- R4: A word with a start marker, for a port already in a packet, leaves with its start marker kept, the error flag set and error code 2 (missing end). The packet restarts, so the port stays in a packet unless that word also carries an end marker.
- R5: Interleaving words of open packets from different ports raises no error.
- R6: A word that carries both start and end markers leaves its port idle.
- R7: Reset clears every port to idle and clears the output valid bit.
- R8: in_ready_o equals (not out_valid_o) or out_ready_i. While out_valid_o is 1 and out_ready_i is 0, every output holds its value.
- R9: An end marker on a port that is idle and has no start marker on the same word is a stray end. The word becomes a single-word packet (start forced to 1) with error code 1, and the port stays idle.
- R10: A word that keeps its port's framing leaves with the error flag at 0 and error code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word present |
| in_ready_o | output | 1 | Input word taken this cycle when valid |
| in_sop_i | input | 1 | Start-of-packet marker |
| in_eop_i | input | 1 | End-of-packet marker |
| in_addr_i | input | 8 | Port address |
| in_data_i | input | DATA_W | Payload |
| out_valid_o | output | 1 | Output word present |
| out_ready_i | input | 1 | Downstream can take the output word |
| out_sop_o | output | 1 | Corrected start marker |
| out_eop_o | output | 1 | End marker |
| out_addr_o | output | 8 | Port address, passed unchanged |
| out_data_o | output | DATA_W | Payload |
| out_err_o | output | 1 | Word was corrected or flagged |
| out_err_code_o | output | 2 | 0 no fault, 1 missing start, 2 missing end |

## Verification
The bench builds the block with NUM_PORTS=4 and DATA_W=16. With these values, only address bits [1:0] select the state, and addresses above 3 alias onto the four checked ports. This lets directed words for address 6 continue a packet that was opened on address 2. Random 8-bit addresses also exercise every upper-bit pattern on the way through. With four ports, random markers drive all four states in a short run, so every state meets every mix of start and end markers, including random downstream stalls.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    FC_OK     = 2'd0,
    FC_NO_SOP = 2'd1,
    FC_NO_EOP = 2'd2
  } fc_err_e;
endpackage

// File: rtl/fc_port_state.sv
module fc_port_state #(
  parameter int NUM_PORTS = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic             busy_o,
  input  logic             wr_en_i,
  input  logic             wr_busy_i
);
  logic [NUM_PORTS-1:0] busy_q;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            busy_q[g] <= 1'b0;
      else if (wr_en_i && idx_i == IDX_W'(g)) busy_q[g] <= wr_busy_i;
    end
  end

  assign busy_o = busy_q[idx_i];
endmodule

// File: rtl/fc_frame_rules.sv
module fc_frame_rules
  import fc_pkg::*;
(
  input  logic    busy_i,
  input  logic    sop_i,
  input  logic    eop_i,
  output logic    sop_o,
  output fc_err_e code_o,
  output logic    next_busy_o
);
  always_comb begin
    sop_o  = sop_i;
    code_o = FC_OK;
    if (!busy_i && !sop_i) begin
      sop_o  = 1'b1;       // open the packet that was never started
      code_o = FC_NO_SOP;
    end else if (busy_i && sop_i) begin
      code_o = FC_NO_EOP;  // previous packet never closed; restart
    end
    next_busy_o = !eop_i;
  end
endmodule

// File: rtl/fc_out_reg.sv
module fc_out_reg
  import fc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  fc_err_e           code_i,
  output logic              valid_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output fc_err_e           code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
      code_o  <= FC_OK;
    end else if (load_i) begin
      valid_o <= valid_i;
      sop_o   <= sop_i;
      eop_o   <= eop_i;
      addr_o  <= addr_i;
      data_o  <= data_i;
      code_o  <= code_i;
    end
  end
endmodule

// File: rtl/fc_frame_checker.sv
module fc_frame_checker
  import fc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_err_o,
  output logic [1:0]        out_err_code_o
);
  localparam int IDX_W = $clog2(NUM_PORTS);

  logic       load;
  logic       accept;
  logic       busy;
  logic       fix_sop;
  logic       next_busy;
  fc_err_e    code_d;
  fc_err_e    code_q;
  logic [IDX_W-1:0] idx;

  assign load   = !out_valid_o || out_ready_i;
  assign accept = in_valid_i && load;
  assign idx    = in_addr_i[IDX_W-1:0];

  assign in_ready_o = load;

  fc_port_state #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (idx),
    .busy_o    (busy),
    .wr_en_i   (accept),
    .wr_busy_i (next_busy)
  );

  fc_frame_rules u_rules (
    .busy_i      (busy),
    .sop_i       (in_sop_i),
    .eop_i       (in_eop_i),
    .sop_o       (fix_sop),
    .code_o      (code_d),
    .next_busy_o (next_busy)
  );

  fc_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .valid_i (in_valid_i),
    .sop_i   (fix_sop),
    .eop_i   (in_eop_i),
    .addr_i  (in_addr_i),
    .data_i  (in_data_i),
    .code_i  (code_d),
    .valid_o (out_valid_o),
    .sop_o   (out_sop_o),
    .eop_o   (out_eop_o),
    .addr_o  (out_addr_o),
    .data_o  (out_data_o),
    .code_o  (code_q)
  );

  assign out_err_code_o = code_q;
  assign out_err_o      = (code_q != FC_OK);
endmodule

// File: rtl/fc_frame_checker_sva.sv
module fc_frame_checker_sva
  import fc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_sop_i,
  input logic              in_eop_i,
  input logic [ADDR_W-1:0] in_addr_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_sop_o,
  input logic              out_eop_o,
  input logic [ADDR_W-1:0] out_addr_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_err_o,
  input logic [1:0]        out_err_code_o
);
  logic acc;
  assign acc = in_valid_i && in_ready_o;

  assert_pass_through_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o && out_addr_o == $past(in_addr_i)
            && out_data_o == $past(in_data_i) && out_eop_o == $past(in_eop_i));

  assert_hold_on_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o)
      && $stable(out_data_o) && $stable(out_sop_o) && $stable(out_eop_o)
      && $stable(out_err_code_o));

  assert_stall_blocks_input_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  assert_sop_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && in_sop_i |=> out_sop_o && out_err_code_o != 2'd1);

  assert_forced_sop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_err_code_o == 2'd1 |-> out_sop_o && out_err_o);

  assert_code_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_err_code_o != 2'd3);
endmodule

bind fc_frame_checker fc_frame_checker_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_valid_i     (in_valid_i),
  .in_ready_o     (in_ready_o),
  .in_sop_i       (in_sop_i),
  .in_eop_i       (in_eop_i),
  .in_addr_i      (in_addr_i),
  .in_data_i      (in_data_i),
  .out_valid_o    (out_valid_o),
  .out_ready_i    (out_ready_i),
  .out_sop_o      (out_sop_o),
  .out_eop_o      (out_eop_o),
  .out_addr_o     (out_addr_o),
  .out_data_o     (out_data_o),
  .out_err_o      (out_err_o),
  .out_err_code_o (out_err_code_o)
);

// File: tb/sim_fc_frame_checker.sv
module sim_fc_frame_checker;
  localparam int CLK_NS = 10;
  localparam int NP     = 4;
  localparam int DW     = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]    in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_ready = 1'b1;
  logic          in_ready, out_valid, out_sop, out_eop, out_err;
  logic [7:0]    out_addr;
  logic [DW-1:0] out_data;
  logic [1:0]    out_code;

  int total = 0;
  int bad   = 0;

  // reference model state
  bit          st [NP];
  bit          m_valid;
  bit          m_sop, m_eop;
  logic [7:0]  m_addr;
  logic [DW-1:0] m_data;
  int          m_code;

  always #(CLK_NS/2) clk = ~clk;

  fc_frame_checker #(.NUM_PORTS(NP), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_sop_i(in_sop),
    .in_eop_i(in_eop), .in_addr_i(in_addr), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_sop_o(out_sop),
    .out_eop_o(out_eop), .out_addr_o(out_addr), .out_data_o(out_data),
    .out_err_o(out_err), .out_err_code_o(out_code)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) st[i] = 1'b0;
      m_valid = 1'b0;
    end else if (!m_valid || out_ready) begin
      m_valid = in_valid;
      if (in_valid) begin
        int p;
        p      = in_addr % NP;
        m_addr = in_addr;
        m_data = in_data;
        m_eop  = in_eop;
        m_sop  = in_sop;
        m_code = 0;
        if (!st[p] && !in_sop) begin m_sop = 1'b1; m_code = 1; end
        else if (st[p] && in_sop) m_code = 2;
        st[p] = !in_eop;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 in_ready", in_ready, !m_valid || out_ready);
      chk("R1 out_valid", out_valid, m_valid);
      if (m_valid) begin
        chk("R1 addr", out_addr, m_addr);
        chk("R1 data", out_data, m_data);
        chk("R1 eop", out_eop, m_eop);
        chk("R3 sop", out_sop, m_sop);
        chk("R10 code", out_code, m_code);
        chk("R10 err", out_err, m_code != 0);
      end
    end
  end

  task automatic put(input logic [7:0] a, input logic s, input logic e);
    @(posedge clk); #1;
    in_valid = 1'b1; in_addr = a; in_sop = s; in_eop = e; in_data = DW'($urandom);
  endtask

  task automatic look(input string tag, input logic s, input logic e, input int code,
                      input logic [7:0] a);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk({tag, " valid"}, out_valid, 1);
    chk({tag, " sop"}, out_sop, s);
    chk({tag, " eop"}, out_eop, e);
    chk({tag, " code"}, out_code, code);
    chk({tag, " err"}, out_err, code != 0);
    chk({tag, " addr"}, out_addr, a);
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 3);
    @(negedge clk);
    chk("R7 valid in reset", out_valid, 0);
    rst_n = 1'b1;

    // R7: after reset every port idle; R1 upper bits kept
    put(8'h40, 0, 1); look("R7", 1, 1, 1, 8'h40);
    // R6: single-word packet leaves port idle
    put(8'h02, 1, 1); look("R6 single", 1, 1, 0, 8'h02);
    put(8'h02, 0, 0); look("R6 next idle", 1, 0, 1, 8'h02);
    // R2: address 6 aliases port 2 which is now open
    put(8'h06, 0, 1); look("R2 alias", 0, 1, 0, 8'h06);
    // R4: start on open packet
    put(8'h01, 1, 0); look("R10 open", 1, 0, 0, 8'h01);
    put(8'h01, 1, 0); look("R4 restart", 1, 0, 2, 8'h01);
    put(8'h01, 0, 1); look("R4 continues", 0, 1, 0, 8'h01);
    // R5: interleaved ports
    put(8'h00, 1, 0); look("R5 a", 1, 0, 0, 8'h00);
    put(8'hF3, 1, 0); look("R5 b", 1, 0, 0, 8'hF3);
    put(8'h00, 0, 1); look("R5 c", 0, 1, 0, 8'h00);
    put(8'h03, 0, 1); look("R5 d", 0, 1, 0, 8'h03);
    // R9: stray end on idle port
    put(8'h03, 0, 1); look("R9 stray", 1, 1, 1, 8'h03);
    put(8'h03, 0, 0); look("R9 still idle", 1, 0, 1, 8'h03);
    put(8'h03, 0, 1); look("R9 close", 0, 1, 0, 8'h03);

    // R8: stall holds output and blocks input
    put(8'h21, 1, 0);
    @(posedge clk); #1;
    out_ready = 1'b0;
    in_addr = 8'h21; in_sop = 1'b0; in_eop = 1'b1; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 held sop", out_sop, 1);
      chk("R8 held eop", out_eop, 0);
      chk("R8 held addr", out_addr, 8'h21);
      chk("R8 blocked", in_ready, 0);
      @(posedge clk); #1;
    end
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 resume eop", out_eop, 1);
    chk("R8 resume code", out_code, 0);

    // random phase, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      in_valid  = ($urandom % 4) != 0;
      in_sop    = ($urandom % 3) == 0;
      in_eop    = ($urandom % 3) == 0;
      in_addr   = 8'($urandom);
      in_data   = DW'($urandom);
      out_ready = ($urandom % 5) != 0;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);

    // R7: reset mid-stream clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R7 valid cleared", out_valid, 0);
    rst_n = 1'b1;
    put(8'h01, 0, 0); look("R7 after reset", 1, 0, 1, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule